// File: doc/BRIEF.md
# Clock-Sliced Four-Task Issue Scheduler

This block picks, on every clock, which of four hardware tasks may issue into a shared core. A programmable sequence of 2-bit task numbers sets the order. The scheduler moves one slot forward on every clock. Each time slice is therefore a single clock, not a single instruction. A task that is blocked gives up its slot, and the pointer still moves on. Because of this, a stalled task never shifts the timing of the other tasks.

A shared resource opens an access window on a periodic strobe. A task that has a pending resource request may use its slot only in a clock where that strobe is high. A task waiting on an external condition also loses its slot until the condition clears. The length of the sequence follows from the loaded pattern. This lets software pick a period that is relatively prime to the resource period, for example 15 slots against an 8-clock window, so every task eventually meets a window.

Top module: `task_slice_sched`

## Requirements
- R1: After reset the sequence is all task 0 with a length of 1, so `grantTask` is 0 on every clock until a load.
- R2: Slot k of a loaded pattern is taken from bits [2k+1:2k], so slot 0 is bits [1:0]. The first slot is used on the clock after the load, and the pointer advances by one slot on every clock.
- R3: The sequence length is 1 plus the index of the highest nonzero slot, or 1 for an all-zero pattern. After the last slot the pointer returns to slot 0. For example, 0xC84 runs the 6-slot loop 0,1,0,2,0,3.
- R4: A pattern whose top slot (bits [31:30]) is 0 runs at most 15 slots; 0x24E4E4E4 runs exactly 15. A nonzero top slot gives 16.
- R5: If the current task has `resReq` set and `resWindow` is low, `issueValid` is low for that clock, and the pointer still advances on the next clock.
- R6: `resGrant` is high exactly when `resWindow` is high, the current task has `resReq` set and that task has no `extWait`.
- R7: If the current task has `extWait` set, `issueValid` is low, and the pointer still advances.
- R8: `grantTask` always shows the current slot's task. `issueValid` is high whenever neither R5 nor R7 blocks that task.
- R9: During the clock in which `seqLoad` is high, the old sequence still drives the outputs. The new pattern takes over from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| seqLoad | input | 1 | Load `seqPattern` as the new slot sequence |
| seqPattern | input | 32 | Sixteen 2-bit task numbers, slot 0 in the low bits |
| resReq | input | 4 | Per-task pending shared-resource request |
| extWait | input | 4 | Per-task wait on an external condition that is not yet met |
| resWindow | input | 1 | Shared-resource window strobe |
| grantTask | output | 2 | Task owning the current slot |
| issueValid | output | 1 | The current task may issue this clock |
| resGrant | output | 1 | The current task takes the resource window this clock |

## Verification
The bench targets wrap-around at lengths 1, 4, 6, 15 and 16. A wrong length calculation would show up as a task order that drifts from the expected one after the first lap. It runs a task with a standing resource request against an 8-clock window under the 15-slot pattern. A design that held the pointer while the task was stalled would freeze the other tasks' order. A design that gated the grant wrongly would grant outside a window. It also checks the load clock itself, where a design that switched patterns too early would show the new slot 0 one clock early.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef struct packed {
    logic loadSeq;
    logic advance;
  } ctrlStrobes_t;
endpackage

// File: rtl/sched_slot_path.sv
module sched_slot_path
  import sched_pkg::*;
#(
  parameter int SLOTS     = 16,
  parameter int ID_W      = 2,
  parameter bit STRIP_ALL = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobes_t          strobes,
  input  logic [SLOTS*ID_W-1:0] pattern,
  output logic [ID_W-1:0]       curTask
);
  localparam int SEQ_W = SLOTS * ID_W;
  localparam int PTR_W = $clog2(SLOTS);

  logic [SEQ_W-1:0] seqReg;
  logic [PTR_W-1:0] slotPtr;
  logic [PTR_W-1:0] lastSlot;
  logic [PTR_W-1:0] newLast;

  // Last slot index derived from the incoming pattern
  generate
    if (STRIP_ALL) begin : g_strip
      always_comb begin
        newLast = '0;
        for (int k = 0; k < SLOTS; k++) begin
          if (pattern[k*ID_W +: ID_W] != '0) newLast = PTR_W'(k);
        end
      end
    end else begin : g_top_only
      always_comb begin
        if (pattern[SEQ_W-1 -: ID_W] == '0) newLast = PTR_W'(SLOTS - 2);
        else                                newLast = PTR_W'(SLOTS - 1);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqReg   <= '0;
      lastSlot <= '0;
      slotPtr  <= '0;
    end else if (strobes.loadSeq) begin
      seqReg   <= pattern;
      lastSlot <= newLast;
      slotPtr  <= '0;
    end else if (strobes.advance) begin
      slotPtr  <= (slotPtr == lastSlot) ? '0 : slotPtr + 1'b1;
    end
  end

  assign curTask = seqReg[slotPtr*ID_W +: ID_W];
endmodule

// File: rtl/sched_issue_ctrl.sv
module sched_issue_ctrl
  import sched_pkg::*;
#(
  parameter int NUM_TASKS = 4,
  parameter int ID_W      = 2
) (
  input  logic                 seqLoad,
  input  logic [ID_W-1:0]      curTask,
  input  logic [NUM_TASKS-1:0] resReq,
  input  logic [NUM_TASKS-1:0] extWait,
  input  logic                 resWindow,
  output ctrlStrobes_t         strobes,
  output logic                 issueValid,
  output logic                 resGrant
);
  logic wantsRes;
  logic extBlocked;

  assign wantsRes   = resReq[curTask];
  assign extBlocked = extWait[curTask];

  // One slice per clock: the pointer never waits for a stalled task
  assign strobes.loadSeq = seqLoad;
  assign strobes.advance = 1'b1;

  assign issueValid = !extBlocked && (!wantsRes || resWindow);
  assign resGrant   = resWindow && wantsRes && !extBlocked;
endmodule

// File: rtl/task_slice_sched.sv
module task_slice_sched
  import sched_pkg::*;
#(
  parameter int NUM_TASKS = 4,
  parameter int SLOTS     = 16,
  parameter bit STRIP_ALL = 1'b1,
  localparam int ID_W     = $clog2(NUM_TASKS),
  localparam int SEQ_W    = SLOTS * ID_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 seqLoad,
  input  logic [SEQ_W-1:0]     seqPattern,
  input  logic [NUM_TASKS-1:0] resReq,
  input  logic [NUM_TASKS-1:0] extWait,
  input  logic                 resWindow,
  output logic [ID_W-1:0]      grantTask,
  output logic                 issueValid,
  output logic                 resGrant
);
  ctrlStrobes_t     strobes;
  logic [ID_W-1:0]  curTask;

  sched_slot_path #(.SLOTS(SLOTS), .ID_W(ID_W), .STRIP_ALL(STRIP_ALL)) u_path (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pattern(seqPattern), .curTask(curTask)
  );

  sched_issue_ctrl #(.NUM_TASKS(NUM_TASKS), .ID_W(ID_W)) u_ctrl (
    .seqLoad(seqLoad), .curTask(curTask), .resReq(resReq), .extWait(extWait),
    .resWindow(resWindow), .strobes(strobes), .issueValid(issueValid), .resGrant(resGrant)
  );

  assign grantTask = curTask;
endmodule

// File: rtl/sched_checker.sv
module sched_checker #(
  parameter int NUM_TASKS = 4,
  parameter int ID_W      = 2,
  parameter int SEQ_W     = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 seqLoad,
  input logic [SEQ_W-1:0]     seqPattern,
  input logic [NUM_TASKS-1:0] resReq,
  input logic [NUM_TASKS-1:0] extWait,
  input logic                 resWindow,
  input logic [ID_W-1:0]      grantTask,
  input logic                 issueValid,
  input logic                 resGrant
);
  assert_grant_in_window_R6: assert property (@(posedge clk) disable iff (!rstN)
    resGrant |-> (resWindow && resReq[grantTask] && !extWait[grantTask]));

  assert_grant_issues_R6: assert property (@(posedge clk) disable iff (!rstN)
    resGrant |-> issueValid);

  assert_res_stall_R5: assert property (@(posedge clk) disable iff (!rstN)
    (resReq[grantTask] && !resWindow) |-> !issueValid);

  assert_ext_stall_R7: assert property (@(posedge clk) disable iff (!rstN)
    extWait[grantTask] |-> !issueValid);

  assert_free_issue_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!extWait[grantTask] && (!resReq[grantTask] || resWindow)) |-> issueValid);

  assert_load_first_slot_R9: assert property (@(posedge clk) disable iff (!rstN)
    seqLoad |=> (grantTask == $past(seqPattern[ID_W-1:0])));
endmodule

bind task_slice_sched sched_checker #(.NUM_TASKS(NUM_TASKS), .ID_W(ID_W), .SEQ_W(SEQ_W)) u_checker (
  .clk(clk), .rstN(rstN), .seqLoad(seqLoad), .seqPattern(seqPattern), .resReq(resReq),
  .extWait(extWait), .resWindow(resWindow), .grantTask(grantTask),
  .issueValid(issueValid), .resGrant(resGrant)
);

// File: tb/test_task_slice_sched.sv
module test_task_slice_sched;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        seqLoad = 1'b0;
  logic [31:0] seqPattern = '0;
  logic [3:0]  resReq = '0;
  logic [3:0]  extWait = '0;
  logic        resWindow = 1'b0;
  logic [1:0]  grantTask;
  logic        issueValid;
  logic        resGrant;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  typedef struct {
    logic [1:0] task_id;
    logic       valid;
    logic       grant;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  event     evCheck;

  // Independent model of the slot order
  logic [31:0] mSeq  = '0;
  int          mLen  = 1;
  int          mPtr  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  task_slice_sched i_task_slice_sched (
    .clk(clk), .rstN(rstN), .seqLoad(seqLoad), .seqPattern(seqPattern),
    .resReq(resReq), .extWait(extWait), .resWindow(resWindow),
    .grantTask(grantTask), .issueValid(issueValid), .resGrant(resGrant)
  );

  function automatic int lenOf(logic [31:0] p);
    int n = 1;
    for (int k = 0; k < 16; k++) if (p[2*k +: 2] != 2'd0) n = k + 1;
    return n;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // Monitor: pops the expected item for this cycle and compares
  always @(evCheck) begin
    expItem_t e;
    if (expQ.size() == 0) begin
      check("R8", "queue underflow", 0, 1);
    end else begin
      e = expQ.pop_front();
      check(e.tag, "grantTask", int'(grantTask), int'(e.task_id));
      check(e.tag, "issueValid", int'(issueValid), int'(e.valid));
      check(e.tag, "resGrant", int'(resGrant), int'(e.grant));
    end
  end

  // Driver: one clock of stimulus, expected outputs pushed to the scoreboard
  task automatic step(string tag, logic ld, logic [31:0] pat, logic [3:0] rq,
                      logic [3:0] ew, logic win);
    expItem_t e;
    logic [1:0] t;
    @(negedge clk);
    seqLoad = ld; seqPattern = pat; resReq = rq; extWait = ew; resWindow = win;
    t = mSeq[2*mPtr +: 2];
    e.task_id = t;
    e.valid   = !ew[t] && !(rq[t] && !win);
    e.grant   = win && rq[t] && !ew[t];
    e.tag     = tag;
    expQ.push_back(e);
    #1 -> evCheck;
    @(posedge clk);
    cyc++;
    if (ld) begin
      mSeq = pat; mLen = lenOf(pat); mPtr = 0;
    end else begin
      mPtr = (mPtr + 1 == mLen) ? 0 : mPtr + 1;
    end
  endtask

  task automatic run(string tag, int n, logic [3:0] rq, logic [3:0] ew, bit periodicWin);
    for (int i = 0; i < n; i++)
      step(tag, 1'b0, 32'h0, rq, ew, periodicWin ? (cyc % 8 == 0) : 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    cyc = 0;
    // R1: reset state, only task 0
    run("R1", 5, 4'b0000, 4'b0000, 1'b0);
    // R9: load clock still uses old sequence; R2: order 0,1,2,3
    step("R9", 1'b1, 32'h0000_00E4, 4'b0000, 4'b0000, 1'b0);
    run("R2", 9, 4'b0000, 4'b0000, 1'b0);
    // R3: 6-slot loop 0,1,0,2,0,3
    step("R9", 1'b1, 32'h0000_0C84, 4'b0000, 4'b0000, 1'b0);
    run("R3", 14, 4'b0000, 4'b0000, 1'b0);
    // R3: all-zero pattern gives length 1
    step("R3", 1'b1, 32'h0000_0000, 4'b0000, 4'b0000, 1'b0);
    run("R3", 4, 4'b0000, 4'b0000, 1'b0);
    // R4: 16 slots, then 15 slots
    step("R4", 1'b1, 32'hE4E4_E4E4, 4'b0000, 4'b0000, 1'b0);
    run("R4", 34, 4'b0000, 4'b0000, 1'b0);
    step("R4", 1'b1, 32'h24E4_E4E4, 4'b0000, 4'b0000, 1'b0);
    run("R4", 32, 4'b0000, 4'b0000, 1'b0);
    // R5/R6: task 1 waits on the resource, window every 8 clocks
    run("R5", 64, 4'b0010, 4'b0000, 1'b1);
    run("R6", 40, 4'b1010, 4'b0000, 1'b1);
    // R7: task 2 waits on an external condition
    step("R7", 1'b1, 32'h0000_00E4, 4'b0000, 4'b0100, 1'b0);
    run("R7", 10, 4'b0000, 4'b0100, 1'b0);
    // R8: mixed blocking across tasks
    run("R8", 24, 4'b1001, 4'b0010, 1'b1);
    run("R6", 16, 4'b0100, 4'b0100, 1'b1);
    @(negedge clk);
    check("R8", "scoreboard drained", expQ.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL R8 watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule